// File: doc/BRIEF.md
# Region Access Permission Checker

This block decides whether a single bus access may go ahead. A request carries the number of the master that issued it, its privilege mode (user or supervisor) and its kind (data read, data write or instruction fetch). The block also receives one hit flag per protection region. Each region has a 32-bit permission word that sets the rights of every master. The access is granted if at least one hitting region allows it. Otherwise the block reports an access error, and the bus must not carry out the transfer.

Masters 0 to 3 have full control. Each has a three-bit user field with separate read, write and execute enables, plus a two-bit supervisor code. One value of that code defers to the user field. Masters 4 to 7 have only a read enable and a write enable, and these apply in both privilege modes. The permission words sit in a small register file with a select-based write and read port. Reserved bits are dropped when written, so they always read as zero. Address matching happens outside the block. The verdict is registered and returned as a one-cycle pulse.

Top module: `region_perm_check`

## Requirements
- R1: For masters 0–3 (m), bits [6m+2:6m] of a word form the user field, with bit 6m+2 = read, bit 6m+1 = write and bit 6m = execute. In user mode, a read, write or fetch is allowed by a region only if the matching bit is 1.
- R2: For masters 0–3, bits [6m+4:6m+3] form the supervisor code. In supervisor mode the code grants rights as follows:
  - 00 grants read, write and execute.
  - 01 grants read and execute.
  - 10 grants read and write.
  - 11 grants the rights of that master's user field.
- R3: For masters 4–7 (k = m−4), bit 24+2k is the write enable and bit 25+2k is the read enable. These bits apply in both privilege modes. An instruction fetch is judged by the read enable.
- R4: The grant is the OR of the decisions of all regions whose hit flag is 1. The permission word of a region whose flag is 0 has no effect.
- R5: A request that hits no region always ends in an error.
- R6: One cycle after a request with req_valid=1, rsp_valid is 1 for exactly one cycle, and exactly one of rsp_grant and rsp_error is 1. Without a request in the previous cycle, all three outputs are 0.
- R7: A write to word cfg_wr_sel stores cfg_wr_data, except that bits 5, 11, 17 and 23 are forced to 0. cfg_rd_data returns the stored word for cfg_rd_sel.
- R8: After reset, every permission word reads 0 and all response outputs are 0.
- R9: Access kind code 3 is reserved. It always ends in an error. The kind codes are 0 = read, 1 = write and 2 = fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Write strobe for a permission word |
| cfg_wr_sel | input | SEL_W | Index of the word to write |
| cfg_wr_data | input | 32 | Write data |
| cfg_rd_sel | input | SEL_W | Index of the word to read |
| cfg_rd_data | output | 32 | Selected word, reserved bits zero |
| req_valid | input | 1 | A request is presented this cycle |
| req_master | input | 3 | Requesting master number |
| req_super | input | 1 | 1 = supervisor mode, 0 = user mode |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 reserved |
| region_hit | input | NUM_REGIONS | Per-region address hit flags |
| rsp_valid | output | 1 | Verdict pulse |
| rsp_grant | output | 1 | Access allowed |
| rsp_error | output | 1 | Access refused; the transfer must be suppressed |

## Verification
The assertions assume the following about the inputs:
- Request inputs are stable at each rising edge.
- A request is judged against the permission words held before any write in the same cycle.
- A write with an out-of-range select changes nothing.

The stimulus respects these assumptions. It drives every input on the falling edge. It reprograms the words only while no request is pending. It then sweeps every master, mode, kind and hit pattern against freshly written words and checks each verdict one edge later.

// File: rtl/rpc_pkg.sv
package rpc_pkg;
    localparam int WORD_W      = 32;
    localparam int MASTER_W    = 3;
    localparam int N_FULL      = 4;
    localparam int FULL_STRIDE = 6;
    localparam int RW_BASE     = 24;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    // Rights triplet order: {read, write, execute}
    localparam logic [2:0] RIGHT_R = 3'b100;
    localparam logic [2:0] RIGHT_W = 3'b010;
    localparam logic [2:0] RIGHT_X = 3'b001;

    function automatic logic [WORD_W-1:0] rsv_mask();
        logic [WORD_W-1:0] m;
        m = '0;
        for (int i = 0; i < N_FULL; i++) begin
            m[FULL_STRIDE*i + 5] = 1'b1;
        end
        return m;
    endfunction
endpackage

// File: rtl/rpc_perm_decode.sv
module rpc_perm_decode
    import rpc_pkg::*;
(
    input  logic [WORD_W-1:0]   word,
    input  logic [MASTER_W-1:0] master,
    input  logic                super_mode,
    input  logic [1:0]          kind,
    output logic                allow
);
    int         mi;
    logic [2:0] need;
    logic [2:0] urights;
    logic [2:0] rights;
    logic [1:0] scode;
    logic       rd_en;
    logic       wr_en;

    always_comb begin
        mi      = int'(master);
        urights = '0;
        rights  = '0;
        scode   = '0;
        rd_en   = 1'b0;
        wr_en   = 1'b0;
        allow   = 1'b0;
        case (acc_kind_e'(kind))
            ACC_READ:  need = RIGHT_R;
            ACC_WRITE: need = RIGHT_W;
            ACC_FETCH: need = RIGHT_X;
            default:   need = 3'b000;
        endcase
        if (mi < N_FULL) begin
            urights = word[FULL_STRIDE*mi +: 3];
            scode   = word[FULL_STRIDE*mi + 3 +: 2];
            if (super_mode) begin
                case (scode)
                    2'b00:   rights = RIGHT_R | RIGHT_W | RIGHT_X;
                    2'b01:   rights = RIGHT_R | RIGHT_X;
                    2'b10:   rights = RIGHT_R | RIGHT_W;
                    default: rights = urights;
                endcase
            end else begin
                rights = urights;
            end
            allow = |(rights & need);
        end else begin
            wr_en = word[RW_BASE + 2*(mi-N_FULL)];
            rd_en = word[RW_BASE + 2*(mi-N_FULL) + 1];
            case (acc_kind_e'(kind))
                ACC_WRITE:           allow = wr_en;
                ACC_READ, ACC_FETCH: allow = rd_en;
                default:             allow = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/rpc_perm_regs.sv
module rpc_perm_regs
    import rpc_pkg::*;
#(
    parameter int NUM_REGIONS = 4,
    localparam int SEL_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic [SEL_W-1:0]                    wr_sel,
    input  logic [WORD_W-1:0]                   wr_data,
    input  logic [SEL_W-1:0]                    rd_sel,
    output logic [WORD_W-1:0]                   rd_data,
    output logic [NUM_REGIONS-1:0][WORD_W-1:0]  words
);
    localparam logic [WORD_W-1:0] RSV = rsv_mask();

    typedef struct packed {
        logic [NUM_REGIONS-1:0][WORD_W-1:0] w;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en && (int'(wr_sel) < NUM_REGIONS)) begin
            regs_d.w[wr_sel] = wr_data & ~RSV;
        end
        rd_data = (int'(rd_sel) < NUM_REGIONS) ? regs_q.w[rd_sel] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign words = regs_q.w;

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(words))
        else $error("words changed without a write");
endmodule

// File: rtl/region_perm_check.sv
module region_perm_check
    import rpc_pkg::*;
#(
    parameter int NUM_REGIONS = 4,
    localparam int SEL_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_wr_en,
    input  logic [SEL_W-1:0]       cfg_wr_sel,
    input  logic [31:0]            cfg_wr_data,
    input  logic [SEL_W-1:0]       cfg_rd_sel,
    output logic [31:0]            cfg_rd_data,
    input  logic                   req_valid,
    input  logic [2:0]             req_master,
    input  logic                   req_super,
    input  logic [1:0]             req_kind,
    input  logic [NUM_REGIONS-1:0] region_hit,
    output logic                   rsp_valid,
    output logic                   rsp_grant,
    output logic                   rsp_error
);
    logic [NUM_REGIONS-1:0][WORD_W-1:0] words;
    logic [NUM_REGIONS-1:0]             allow_vec;
    logic                               any_grant;

    typedef struct packed {
        logic valid;
        logic grant;
        logic error;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    rpc_perm_regs #(.NUM_REGIONS(NUM_REGIONS)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_sel  (cfg_wr_sel),
        .wr_data (cfg_wr_data),
        .rd_sel  (cfg_rd_sel),
        .rd_data (cfg_rd_data),
        .words   (words)
    );

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
        rpc_perm_decode u_dec (
            .word       (words[g]),
            .master     (req_master),
            .super_mode (req_super),
            .kind       (req_kind),
            .allow      (allow_vec[g])
        );
    end

    always_comb begin
        any_grant   = |(allow_vec & region_hit);
        rsp_d       = '0;
        rsp_d.valid = req_valid;
        rsp_d.grant = req_valid &  any_grant;
        rsp_d.error = req_valid & ~any_grant;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_grant = rsp_q.grant;
    assign rsp_error = rsp_q.error;

    p_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid)
        else $error("no verdict after request");
    p_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid && !rsp_grant && !rsp_error)
        else $error("verdict without request");
    p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $countones({rsp_grant, rsp_error}) == 1)
        else $error("grant and error not exclusive");
    p_nohit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && region_hit == '0) |=> rsp_error)
        else $error("grant with no region hit");
    p_rsvd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'd3) |=> rsp_error)
        else $error("reserved kind granted");
endmodule

// File: tb/region_perm_check_test.sv
module region_perm_check_test;
    localparam int NR = 4;
    localparam int SW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr_en = 1'b0;
    logic [SW-1:0] cfg_wr_sel = '0;
    logic [31:0]   cfg_wr_data = '0;
    logic [SW-1:0] cfg_rd_sel = '0;
    logic [31:0]   cfg_rd_data;
    logic          req_valid = 1'b0;
    logic [2:0]    req_master = '0;
    logic          req_super = 1'b0;
    logic [1:0]    req_kind = '0;
    logic [NR-1:0] region_hit = '0;
    logic          rsp_valid, rsp_grant, rsp_error;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [31:0] shadow [NR];

    always #2 clk = ~clk;

    region_perm_check #(.NUM_REGIONS(NR)) uut (.*);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit region_ok(logic [31:0] w, int m, bit s, int k);
        logic [2:0] u, r, need;
        int sc;
        if (k == 3) return 0;
        if (m >= 4) begin
            if (k == 1) return w[24 + 2*(m-4)];
            return w[25 + 2*(m-4)];
        end
        u  = w[6*m +: 3];
        sc = int'(w[6*m+3 +: 2]);
        if (!s)           r = u;
        else if (sc == 0) r = 3'b111;
        else if (sc == 1) r = 3'b101;
        else if (sc == 2) r = 3'b110;
        else              r = u;
        need = (k == 0) ? 3'b100 : (k == 1) ? 3'b010 : 3'b001;
        return |(r & need);
    endfunction

    task automatic write_word(input int idx, input logic [31:0] val);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_sel = SW'(idx); cfg_wr_data = val;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        shadow[idx] = val & ~32'h0082_0820;
        cfg_rd_sel = SW'(idx);
        #0.1;
        chk(cfg_rd_data == shadow[idx], "R7 readback", cfg_rd_data, shadow[idx]);
    endtask

    task automatic do_req(input int m, input bit s, input int k, input int hit);
        bit exp_g;
        string tag;
        exp_g = 0;
        for (int r = 0; r < NR; r++)
            if (hit[r] && region_ok(shadow[r], m, s, k)) exp_g = 1;
        if (hit == 0)                 tag = "R5 nohit";
        else if (k == 3)              tag = "R9 rsvd kind";
        else if ($countones(hit) > 1) tag = "R4 multi-hit";
        else if (m >= 4)              tag = "R3 rw master";
        else if (s)                   tag = "R2 super";
        else                          tag = "R1 user";
        @(negedge clk);
        req_valid = 1'b1; req_master = 3'(m); req_super = s;
        req_kind = 2'(k); region_hit = NR'(hit);
        @(negedge clk);
        req_valid = 1'b0;
        chk(rsp_valid && rsp_grant == exp_g && rsp_error == !exp_g, tag,
            {29'b0, rsp_valid, rsp_grant, rsp_error}, {29'b0, 1'b1, exp_g, !exp_g});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        for (int i = 0; i < NR; i++) begin
            cfg_rd_sel = SW'(i);
            #0.1;
            chk(cfg_rd_data == 0, "R8 reset word", cfg_rd_data, 0);
        end
        chk(!rsp_valid && !rsp_grant && !rsp_error, "R8 reset rsp",
            {29'b0, rsp_valid, rsp_grant, rsp_error}, 0);
        rst_n = 1'b1;
        for (int i = 0; i < NR; i++) shadow[i] = '0;
        // R2: zero words still give supervisor rights on full masters
        do_req(0, 1, 1, 1);
        do_req(5, 1, 0, 1);
        // R7: reserved bits dropped
        write_word(0, 32'hFFFF_FFFF);
        write_word(1, 32'h0082_0820);
        for (int t = 0; t < 16; t++) begin
            for (int i = 0; i < NR; i++) write_word(i, $urandom());
            for (int m = 0; m < 8; m++)
                for (int s = 0; s < 2; s++)
                    for (int k = 0; k < 4; k++)
                        for (int h = 0; h < (1 << NR); h++)
                            do_req(m, s[0], k, h);
            // R6: one-cycle pulse then quiet
            @(negedge clk);
            chk(!rsp_valid && !rsp_grant && !rsp_error, "R6 quiet",
                {29'b0, rsp_valid, rsp_grant, rsp_error}, 0);
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule